// File: doc/BRIEF.md
# Random-Access Transmit Keyer for a Half-Duplex Radio Link

This block decides when a shared radio channel may be taken, using p-persistent carrier-sense access, and then drives the push-to-talk line through the whole transmission. When frames wait and the channel looks free, it draws a random number and compares it against a persistence setting. If the draw loses or the channel is busy, it waits a slot time and tries again. When the draw wins, it raises the push-to-talk line, waits out a key-up delay, can wait for the modem's clear-to-send, and then pulses a start strobe to the frame sender.

While the transmitter is keyed, each frame-complete strobe from the sender either starts the next queued frame at once or, when nothing is left, begins a tail period after which push-to-talk drops. All timing runs off a 10 ms tick made by dividing a 1200 Hz reference edge stream by twelve. Full-duplex operation skips the whole access procedure. An optional soft carrier mode treats a receiver that has left hunt mode as a busy channel, and it restarts the slot wait when a received frame ends.

All pins are plain control and status levels or single-cycle strobes. No data passes through the block, so it has no valid/ready stream and applies no back-pressure. The frame sender must hold each frame until `start_frame` pulses and must report its end with one `frame_done` pulse.

Top module: `csma_keyer`

## Requirements
- R1: After reset `rts` and `start_frame` are low, the keyer is idle and no frames are counted as pending.
- R2: In idle with frames pending in half duplex, the random value is the low seven bits of `rand_byte` doubled (an even value 0..254). The keyer keys up only when `persist` is greater than or equal to that value and the channel is clear, so `persist` = 255 always wins.
- R3: A lost draw or a busy channel (`carrier_det` high) loads the timer with `slot_time` and enters slot wait. When the timer reaches zero the keyer returns to idle and draws again.
- R4: With `full_duplex` high the draw and all carrier checks are skipped, and pending frames key the transmitter directly.
- R5: Key-up raises `rts` on the next clock edge and loads `tx_delay` into the timer. When that timer reaches zero the keyer enters the clear-to-send wait. `rts` stays high from key-up to the end of the tail.
- R6: From the clear-to-send wait the keyer starts transmitting once `cts` is high or `cts_gate_en` is low. Entering transmission pulses `start_frame` for exactly one cycle.
- R7: The timer decrements once per tick and holds at zero. One tick occurs on every twelfth `ref_edge` pulse.
- R8: A `frame_done` pulse that leaves frames pending pulses `start_frame` on the next edge, and `rts` stays high.
- R9: A `frame_done` pulse that leaves nothing pending loads `tail_time`. `rts` falls when that timer reaches zero, and the keyer returns to idle.
- R10: With `soft_cd_en` high, a receiver out of hunt mode (`rx_hunt` low) counts as a busy channel.
- R11: In half duplex with `soft_cd_en` high, an `rx_frame_end` pulse while the keyer is idle or in slot wait reloads `slot_time` and enters slot wait.
- R12: The pending count rises on `frame_enq` and falls on `frame_done`. Both in one cycle leave it unchanged, and `frame_done` at zero leaves it at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_edge | input | 1 | One-cycle pulse per edge of the 1200 Hz reference |
| frame_enq | input | 1 | One frame added to the transmit queue |
| frame_done | input | 1 | Frame sender finished the current frame |
| carrier_det | input | 1 | Hardware carrier detect, high = busy |
| rx_hunt | input | 1 | Receiver is hunting for a flag (no frame in progress) |
| rx_frame_end | input | 1 | One-cycle pulse when a received frame ends |
| cts | input | 1 | Modem clear-to-send |
| rand_byte | input | 8 | Random byte from an LFSR |
| persist | input | 8 | Persistence threshold |
| slot_time | input | 8 | Slot wait in ticks |
| tx_delay | input | 8 | Key-up delay in ticks |
| tail_time | input | 8 | Tail period in ticks |
| full_duplex | input | 1 | Bypass channel access |
| cts_gate_en | input | 1 | Wait for `cts` before transmitting |
| soft_cd_en | input | 1 | Use receiver state as carrier detect |
| rts | output | 1 | Push-to-talk / request-to-send |
| start_frame | output | 1 | One-cycle pulse: send the next frame |

## Verification
The bound checker watches every cycle for the invariants that tie the outputs to the sequencer's state. A start strobe never appears without push-to-talk. Push-to-talk falls only out of the tail. A gated clear-to-send wait never advances while `cts` is low. The key-up delay timer moves down by at most one per cycle, and full duplex never enters slot wait. Whether the draw is decided correctly, how many ticks each wait lasts, and how the pending count handles simultaneous and spurious strobes can only be shown by the bench. Its behavioural model is compared with `rts` and `start_frame` on every clock through persistence boundaries, busy channels, repeated slot restarts and back-to-back frames.

// File: rtl/csma_keyer_pkg.sv
package csma_keyer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SLOT = 3'd1,
    ST_TXD  = 3'd2,
    ST_CTSW = 3'd3,
    ST_XMIT = 3'd4,
    ST_TAIL = 3'd5
  } key_state_t;
endpackage

// File: rtl/ref_tick_div.sv
module ref_tick_div #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_edge,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] cnt_q;

  assign tick = ref_edge && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (ref_edge) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + DW'(1);
  end
endmodule

// File: rtl/frame_backlog.sv
module frame_backlog #(
  parameter int CW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enq,
  input  logic done,
  output logic any_pending,
  output logic more_after_done
);
  localparam logic [CW-1:0] FULL = '1;

  logic [CW-1:0] cnt_q;
  logic inc, dec;

  assign inc = enq && (cnt_q != FULL);
  assign dec = done && (cnt_q != '0);
  assign any_pending = (cnt_q != '0);
  // frames left once the current one is retired
  assign more_after_done = (cnt_q > CW'(1)) || enq;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (inc && !dec) cnt_q <= cnt_q + CW'(1);
    else if (dec && !inc) cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic [TW-1:0] value,
  output logic          expired
);
  logic [TW-1:0] val_q;

  assign value   = val_q;
  assign expired = (val_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) val_q <= '0;
    else if (load) val_q <= load_val;
    else if (tick && val_q != '0) val_q <= val_q - TW'(1);
  end
endmodule

// File: rtl/keyer_fsm.sv
module keyer_fsm
  import csma_keyer_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_pending,
  input  logic          more_after_done,
  input  logic          frame_done,
  input  logic          timer_zero,
  input  logic          carrier_det,
  input  logic          rx_hunt,
  input  logic          rx_frame_end,
  input  logic          cts,
  input  logic [TW-1:0] rand_byte,
  input  logic [TW-1:0] persist,
  input  logic [TW-1:0] slot_time,
  input  logic [TW-1:0] tx_delay,
  input  logic [TW-1:0] tail_time,
  input  logic          full_duplex,
  input  logic          cts_gate_en,
  input  logic          soft_cd_en,
  output key_state_t    state,
  output logic          load,
  output logic [TW-1:0] load_val,
  output logic          rts,
  output logic          start_frame
);
  key_state_t st_q, st_d;
  logic rts_q, rts_d, start_q, start_d;
  logic [TW-1:0] draw;
  logic win, busy, restart;

  assign draw    = {rand_byte[TW-2:0], 1'b0};
  assign win     = (persist >= draw);
  assign busy    = carrier_det || (soft_cd_en && !rx_hunt);
  assign restart = !full_duplex && soft_cd_en && rx_frame_end &&
                   (st_q == ST_IDLE || st_q == ST_SLOT);

  always_comb begin
    st_d     = st_q;
    rts_d    = rts_q;
    start_d  = 1'b0;
    load     = 1'b0;
    load_val = '0;
    if (restart) begin
      st_d     = ST_SLOT;
      load     = 1'b1;
      load_val = slot_time;
    end else begin
      case (st_q)
        ST_IDLE: if (any_pending) begin
          if (full_duplex || (win && !busy)) begin
            st_d     = ST_TXD;
            rts_d    = 1'b1;
            load     = 1'b1;
            load_val = tx_delay;
          end else begin
            st_d     = ST_SLOT;
            load     = 1'b1;
            load_val = slot_time;
          end
        end
        ST_SLOT: if (timer_zero) st_d = ST_IDLE;
        ST_TXD:  if (timer_zero) st_d = ST_CTSW;
        ST_CTSW: if (cts || !cts_gate_en) begin
          st_d    = ST_XMIT;
          start_d = 1'b1;
        end
        ST_XMIT: if (frame_done) begin
          if (more_after_done) start_d = 1'b1;
          else begin
            st_d     = ST_TAIL;
            load     = 1'b1;
            load_val = tail_time;
          end
        end
        ST_TAIL: if (timer_zero) begin
          st_d  = ST_IDLE;
          rts_d = 1'b0;
        end
        default: begin
          st_d  = ST_IDLE;
          rts_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rts_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      rts_q   <= rts_d;
      start_q <= start_d;
    end
  end

  assign state       = st_q;
  assign rts         = rts_q;
  assign start_frame = start_q;
endmodule

// File: rtl/csma_keyer.sv
module csma_keyer
  import csma_keyer_pkg::*;
#(
  parameter int TW       = 8,
  parameter int TICK_DIV = 12,
  parameter int CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_edge,
  input  logic          frame_enq,
  input  logic          frame_done,
  input  logic          carrier_det,
  input  logic          rx_hunt,
  input  logic          rx_frame_end,
  input  logic          cts,
  input  logic [TW-1:0] rand_byte,
  input  logic [TW-1:0] persist,
  input  logic [TW-1:0] slot_time,
  input  logic [TW-1:0] tx_delay,
  input  logic [TW-1:0] tail_time,
  input  logic          full_duplex,
  input  logic          cts_gate_en,
  input  logic          soft_cd_en,
  output logic          rts,
  output logic          start_frame
);
  logic          tick, any_pending, more_after_done, timer_zero, load;
  logic [TW-1:0] load_val, timer_q;
  key_state_t    state_q;

  ref_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .tick(tick)
  );

  frame_backlog #(.CW(CW)) u_backlog (
    .clk(clk), .rst_n(rst_n), .enq(frame_enq), .done(frame_done),
    .any_pending(any_pending), .more_after_done(more_after_done)
  );

  hold_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .load_val(load_val),
    .value(timer_q), .expired(timer_zero)
  );

  keyer_fsm #(.TW(TW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .any_pending(any_pending),
    .more_after_done(more_after_done), .frame_done(frame_done),
    .timer_zero(timer_zero), .carrier_det(carrier_det), .rx_hunt(rx_hunt),
    .rx_frame_end(rx_frame_end), .cts(cts), .rand_byte(rand_byte),
    .persist(persist), .slot_time(slot_time), .tx_delay(tx_delay),
    .tail_time(tail_time), .full_duplex(full_duplex), .cts_gate_en(cts_gate_en),
    .soft_cd_en(soft_cd_en), .state(state_q), .load(load), .load_val(load_val),
    .rts(rts), .start_frame(start_frame)
  );
endmodule

// File: rtl/csma_keyer_chk.sv
module csma_keyer_chk
  import csma_keyer_pkg::*;
#(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rts,
  input logic          start_frame,
  input logic          cts,
  input logic          cts_gate_en,
  input logic          full_duplex,
  input key_state_t    state_q,
  input logic [TW-1:0] timer_q
);
  // R6
  start_needs_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_frame |-> rts);

  // R9
  rts_drop_from_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts) |-> $past(state_q) == ST_TAIL);

  // R6
  cts_gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CTSW && cts_gate_en && !cts) |=> state_q == ST_CTSW);

  // R5
  rts_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE || state_q == ST_SLOT) |=>
      (rts == (state_q != ST_IDLE && state_q != ST_SLOT)));

  // R7
  delay_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TXD && $past(state_q) == ST_TXD) |->
      (timer_q == $past(timer_q) || timer_q == $past(timer_q) - TW'(1)));

  // R4
  duplex_no_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && state_q == ST_IDLE) |=> state_q != ST_SLOT);
endmodule

bind csma_keyer csma_keyer_chk #(.TW(TW)) i_chk (
  .clk(clk), .rst_n(rst_n), .rts(rts), .start_frame(start_frame),
  .cts(cts), .cts_gate_en(cts_gate_en), .full_duplex(full_duplex),
  .state_q(state_q), .timer_q(timer_q)
);

// File: tb/test_csma_keyer.sv
module test_csma_keyer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_edge = 1'b0, frame_enq = 1'b0, frame_done = 1'b0;
  logic carrier_det = 1'b0, rx_hunt = 1'b1, rx_frame_end = 1'b0, cts = 1'b0;
  logic [7:0] rand_byte = 8'd0, persist = 8'd255, slot_time = 8'd2;
  logic [7:0] tx_delay = 8'd2, tail_time = 8'd2;
  logic full_duplex = 1'b0, cts_gate_en = 1'b0, soft_cd_en = 1'b0;
  logic rts, start_frame;

  int total = 0, fails = 0, starts = 0;
  bit  done_flag = 0;

  always #5 clk = ~clk;

  csma_keyer i_csma_keyer (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .frame_enq(frame_enq),
    .frame_done(frame_done), .carrier_det(carrier_det), .rx_hunt(rx_hunt),
    .rx_frame_end(rx_frame_end), .cts(cts), .rand_byte(rand_byte),
    .persist(persist), .slot_time(slot_time), .tx_delay(tx_delay),
    .tail_time(tail_time), .full_duplex(full_duplex), .cts_gate_en(cts_gate_en),
    .soft_cd_en(soft_cd_en), .rts(rts), .start_frame(start_frame)
  );

  // reference edge: a pulse on every second cycle
  always @(negedge clk) ref_edge <= ~ref_edge;

  // behavioural reference model
  int m_phase, m_left, m_div, m_pend;
  int m_rts, m_start;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_div = 0; m_pend = 0; m_rts = 0; m_start = 0;
    end else begin
      bit t, ld;
      int nl;
      t = ref_edge && (m_div == 11);
      if (ref_edge) m_div = (m_div + 1) % 12;
      ld = 0; nl = 0; m_start = 0;
      if (!full_duplex && soft_cd_en && rx_frame_end && m_phase <= 1) begin
        m_phase = 1; ld = 1; nl = slot_time;
      end else if (m_phase == 0) begin
        if (m_pend > 0) begin
          if (full_duplex || (int'(persist) >= 2 * int'(rand_byte % 128) &&
              !carrier_det && !(soft_cd_en && !rx_hunt))) begin
            m_phase = 2; m_rts = 1; ld = 1; nl = tx_delay;
          end else begin
            m_phase = 1; ld = 1; nl = slot_time;
          end
        end
      end else if (m_phase == 1) begin
        if (m_left == 0) m_phase = 0;
      end else if (m_phase == 2) begin
        if (m_left == 0) m_phase = 3;
      end else if (m_phase == 3) begin
        if (cts || !cts_gate_en) begin m_phase = 4; m_start = 1; end
      end else if (m_phase == 4) begin
        if (frame_done) begin
          if (m_pend - 1 + (frame_enq ? 1 : 0) > 0) m_start = 1;
          else begin m_phase = 5; ld = 1; nl = tail_time; end
        end
      end else if (m_phase == 5) begin
        if (m_left == 0) begin m_phase = 0; m_rts = 0; end
      end
      if (ld) m_left = nl;
      else if (t && m_left > 0) m_left = m_left - 1;
      if (frame_done && m_pend > 0) m_pend = m_pend - 1;
      if (frame_enq && m_pend < 15) m_pend = m_pend + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done_flag) begin
    if (start_frame) starts++;
    if (rts !== m_rts[0]) check(0, "R5 rts vs model", int'(rts), m_rts);
    else total++;
    if (start_frame !== m_start[0]) check(0, "R6 start_frame vs model", int'(start_frame), m_start);
    else total++;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_enq();
    frame_enq = 1'b1; step(1); frame_enq = 1'b0;
  endtask

  task automatic pulse_done();
    frame_done = 1'b1; step(1); frame_done = 1'b0;
  endtask

  task automatic wait_rts(input bit v, input int max, output int took);
    took = -1;
    for (int i = 0; i < max; i++) begin
      if (rts == v) begin took = i; break; end
      step(1);
    end
  endtask

  task automatic wait_start(input int s0, input int max, output int took);
    took = -1;
    for (int i = 0; i < max; i++) begin
      if (starts > s0) begin took = i; break; end
      step(1);
    end
  endtask

  task automatic finish_frame(input string tag);
    int took;
    wait_start(starts - 1 < 0 ? 0 : starts, 400, took);
    step(4);
    pulse_done();
    wait_rts(1'b0, 400, took);
    check(took >= 0, tag, int'(rts), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int took, s0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1
    check(rts == 0 && start_frame == 0, "R1 reset outputs", int'(rts), 0);

    // R4: full duplex keys despite carrier, zero persistence, large draw
    full_duplex = 1; carrier_det = 1; persist = 0; rand_byte = 8'hFF;
    s0 = starts;
    pulse_enq();
    step(1);
    check(rts == 1, "R4 full duplex keys up", int'(rts), 1);
    // R7 / R5: two-tick delay before the start strobe
    wait_start(s0, 200, took);
    check(took >= 22 && took <= 52, "R7 tx delay length", took, 36);
    step(1);
    check(start_frame == 0, "R6 start is a single pulse", int'(start_frame), 0);
    pulse_done();
    step(3);
    check(rts == 1, "R9 rts held through tail", int'(rts), 1);
    wait_rts(1'b0, 100, took);
    check(took >= 0, "R9 rts drops after tail", int'(rts), 0);

    // R6: clear-to-send gating
    cts_gate_en = 1; cts = 0; s0 = starts;
    pulse_enq();
    step(200);
    check(rts == 1 && starts == s0, "R6 waits for cts", starts - s0, 0);
    cts = 1;
    step(3);
    check(starts == s0 + 1, "R6 starts after cts", starts - s0, 1);
    cts_gate_en = 0; cts = 0;

    // R8: second frame under the same key-up
    pulse_enq();
    step(3);
    s0 = starts;
    pulse_done();
    step(1);
    check(starts == s0 + 1 && rts == 1, "R8 back-to-back start", starts - s0, 1);
    // R12: simultaneous enqueue and completion keeps one pending
    step(3);
    s0 = starts;
    frame_enq = 1; frame_done = 1; step(1); frame_enq = 0; frame_done = 0;
    step(1);
    check(starts == s0 + 1, "R12 enq+done restarts", starts - s0, 1);
    step(3);
    pulse_done();
    wait_rts(1'b0, 100, took);
    check(took >= 0, "R12 count back to zero", int'(rts), 0);

    // R12: completion at zero must not underflow
    pulse_done();
    step(5);
    pulse_enq();
    finish_frame("R12 no underflow after spurious done");
    step(60);
    check(rts == 0, "R12 stays idle", int'(rts), 0);

    // R2: lost draw (128 > 100)
    full_duplex = 0; carrier_det = 0; persist = 8'd100; rand_byte = 8'h40;
    pulse_enq();
    step(150);
    check(rts == 0, "R2 lost draw holds off", int'(rts), 0);
    // R2 boundary: draw 100 equals persistence
    rand_byte = 8'hB2;
    wait_rts(1'b1, 100, took);
    check(took >= 0, "R2 equal draw keys", int'(rts), 1);
    finish_frame("R2 frame completes");

    // R3: busy carrier defers even with persist 255
    persist = 8'd255; rand_byte = 8'h7F; carrier_det = 1;
    pulse_enq();
    step(200);
    check(rts == 0, "R3 carrier defers", int'(rts), 0);
    carrier_det = 0;
    wait_rts(1'b1, 100, took);
    check(took >= 0, "R3 redraw after slot", int'(rts), 1);
    finish_frame("R3 frame completes");

    // R10: soft carrier detect
    soft_cd_en = 1; rx_hunt = 0;
    pulse_enq();
    step(200);
    check(rts == 0, "R10 receiver busy defers", int'(rts), 0);
    rx_hunt = 1;
    wait_rts(1'b1, 100, took);
    check(took >= 0, "R10 keys when hunting", int'(rts), 1);
    finish_frame("R10 frame completes");

    // R11: received frame ends keep restarting the slot wait
    carrier_det = 1;
    pulse_enq();
    step(10);
    carrier_det = 0;
    for (int k = 0; k < 15; k++) begin
      rx_frame_end = 1; step(1); rx_frame_end = 0; step(19);
    end
    check(rts == 0, "R11 slot restarted", int'(rts), 0);
    wait_rts(1'b1, 100, took);
    check(took >= 0, "R11 keys after restarts stop", int'(rts), 1);
    finish_frame("R11 frame completes");

    step(5);
    done_flag = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule